// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block is a fully associative translation lookaside buffer holding a small, parameterised number of entries. Each entry maps one virtual page pair onto two physical frames: an even frame and an odd frame. A page mask per entry sets the size of the pair, and the smallest pair spans 8 KiB. Each entry also has a global bit, and each half has its own valid bit and dirty bit.

A lookup takes a virtual address, an access type (read or write) and the current 8-bit address-space identifier. It returns three things at once, combinationally, in the same cycle: a physical address, a write-permission flag and a 3-bit result code. When the request strobe is high, the block also captures those outputs into a response register, which holds them until the next request. Entries are loaded through a write port that takes an index and the entry fields.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset every entry field is zero and `rsp_valid_o`, `rsp_pa_o`, `rsp_wr_perm_o` and `rsp_res_o` are zero.
- R2: An entry hits when its global bit is set or its stored identifier equals `asid_i`, and also its stored VPN equals `va_i` with the effective-mask bits cleared. The effective mask is the entry's mask ORed with 0x1FFF.
- R3: The half is selected by the address bit at the top set position of the effective mask: 0 selects even, 1 selects odd. The physical address is the selected frame ORed with `va_i & (effective_mask >> 1)`.
- R4: A hit whose selected half has its valid bit clear returns INVALID, code 3'b101.
- R5: A read of a valid half returns MATCH, code 3'b000. A write returns MATCH only when the selected dirty bit is set, and returns DIRTY, code 3'b100, otherwise.
- R6: `wr_perm_o` is 1 exactly when the result is MATCH and the selected dirty bit is set. `pa_o` is zero for any result other than MATCH.
- R7: When several entries hit, the lowest index decides the result, even when that result is a fault.
- R8: When no entry hits, the result is NOMATCH, code 3'b110. The code 3'b111 is reserved for a bad-address result, which this block never produces.
- R9: When `req_i` is high at a clock edge, the response outputs take the lookup outputs of that cycle and `rsp_valid_o` is high for one cycle. While `req_i` is low, `rsp_valid_o` is 0 and the response data holds.
- R10: An entry write takes effect at the clock edge that samples `we_i`. A lookup in the same cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe for the response register |
| va_i | input | VA_W | Virtual address to translate |
| wr_i | input | 1 | Access type: 1 = write, 0 = read |
| asid_i | input | ASID_W | Current address-space identifier |
| we_i | input | 1 | Entry write enable |
| widx_i | input | IDX_W | Index of the entry to write |
| wvpn_i | input | VA_W | Virtual page-pair tag to store |
| wmask_i | input | VA_W | Page mask to store |
| wasid_i | input | ASID_W | Identifier to store |
| wglobal_i | input | 1 | Global bit to store |
| wpfn0_i | input | PA_W | Even frame base |
| wpfn1_i | input | PA_W | Odd frame base |
| wv0_i | input | 1 | Even valid bit |
| wv1_i | input | 1 | Odd valid bit |
| wd0_i | input | 1 | Even dirty bit |
| wd1_i | input | 1 | Odd dirty bit |
| pa_o | output | PA_W | Combinational physical address |
| wr_perm_o | output | 1 | Combinational write permission |
| res_o | output | 3 | Combinational result code |
| rsp_valid_o | output | 1 | Registered response valid |
| rsp_pa_o | output | PA_W | Registered physical address |
| rsp_wr_perm_o | output | 1 | Registered write permission |
| rsp_res_o | output | 3 | Registered result code |

## Verification
The bench builds the block with four entries and 32-bit virtual and physical addresses. With only four entries, every index can be loaded, including the last one. The bench places two entries that overlap on the same page pair, which exercises the first-hit priority in both directions: the lower entry faults in one case and misses in the other. It also loads one entry with a non-zero page mask, which moves the half-select bit to position 14 and widens the offset, so the bench can check masked tag bits and a bit just above the mask.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  typedef enum logic [2:0] {
    RES_MATCH   = 3'b000,
    RES_BADADDR = 3'b111,
    RES_NOMATCH = 3'b110,
    RES_INVALID = 3'b101,
    RES_DIRTY   = 3'b100
  } tlb_res_e;

  // smallest page pair is 2**MIN_OFF_W bytes
  localparam int unsigned MIN_OFF_W = 13;
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned ASID_W    = 8,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [VA_W-1:0]   wvpn_i,
  input  logic [VA_W-1:0]   wmask_i,
  input  logic [ASID_W-1:0] wasid_i,
  input  logic              wglobal_i,
  input  logic [PA_W-1:0]   wpfn0_i,
  input  logic [PA_W-1:0]   wpfn1_i,
  input  logic              wv0_i,
  input  logic              wv1_i,
  input  logic              wd0_i,
  input  logic              wd1_i,
  output logic [VA_W-1:0]   vpn_o    [N_ENTRIES],
  output logic [VA_W-1:0]   mask_o   [N_ENTRIES],
  output logic [ASID_W-1:0] asid_o   [N_ENTRIES],
  output logic              global_o [N_ENTRIES],
  output logic [PA_W-1:0]   pfn0_o   [N_ENTRIES],
  output logic [PA_W-1:0]   pfn1_o   [N_ENTRIES],
  output logic              v0_o     [N_ENTRIES],
  output logic              v1_o     [N_ENTRIES],
  output logic              d0_o     [N_ENTRIES],
  output logic              d1_o     [N_ENTRIES]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        vpn_o[i]    <= '0;
        mask_o[i]   <= '0;
        asid_o[i]   <= '0;
        global_o[i] <= 1'b0;
        pfn0_o[i]   <= '0;
        pfn1_o[i]   <= '0;
        v0_o[i]     <= 1'b0;
        v1_o[i]     <= 1'b0;
        d0_o[i]     <= 1'b0;
        d1_o[i]     <= 1'b0;
      end
    end else if (we_i && (32'(widx_i) < N_ENTRIES)) begin
      vpn_o[widx_i]    <= wvpn_i;
      mask_o[widx_i]   <= wmask_i;
      asid_o[widx_i]   <= wasid_i;
      global_o[widx_i] <= wglobal_i;
      pfn0_o[widx_i]   <= wpfn0_i;
      pfn1_o[widx_i]   <= wpfn1_i;
      v0_o[widx_i]     <= wv0_i;
      v1_o[widx_i]     <= wv1_i;
      d0_o[widx_i]     <= wd0_i;
      d1_o[widx_i]     <= wd1_i;
    end
  end

  // R10: written fields visible after the edge
  a_r10_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (32'(widx_i) < N_ENTRIES)) |=>
      (vpn_o[$past(widx_i)] == $past(wvpn_i)) && (pfn0_o[$past(widx_i)] == $past(wpfn0_i)));
endmodule

// File: rtl/tlb_match_slice.sv
module tlb_match_slice
  import tlb_lookup_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned ASID_W = 8
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VA_W-1:0]   vpn_i,
  input  logic [VA_W-1:0]   mask_i,
  input  logic [ASID_W-1:0] easid_i,
  input  logic              global_i,
  input  logic [PA_W-1:0]   pfn0_i,
  input  logic [PA_W-1:0]   pfn1_i,
  input  logic              v0_i,
  input  logic              v1_i,
  input  logic              d0_i,
  input  logic              d1_i,
  output logic              hit_o,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [PA_W-1:0]   pa_o
);
  localparam logic [VA_W-1:0] MIN_MASK = {{(VA_W-MIN_OFF_W){1'b0}}, {MIN_OFF_W{1'b1}}};

  logic [VA_W-1:0] emask;
  logic [VA_W-1:0] half_mask;
  logic            odd;

  always_comb begin
    emask     = mask_i | MIN_MASK;
    half_mask = emask >> 1;
    odd       = |(va_i & emask & ~half_mask);
    hit_o     = (global_i || (easid_i == asid_i)) && (vpn_i == (va_i & ~emask));
    valid_o   = odd ? v1_i : v0_i;
    dirty_o   = odd ? d1_i : d0_i;
    pa_o      = (odd ? pfn1_i : pfn0_i) | PA_W'(va_i & half_mask);
  end
endmodule

// File: rtl/tlb_priority_sel.sv
module tlb_priority_sel
  import tlb_lookup_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned PA_W      = 32
) (
  input  logic [N_ENTRIES-1:0] hit_i,
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic [N_ENTRIES-1:0] dirty_i,
  input  logic [PA_W-1:0]      pa_i [N_ENTRIES],
  input  logic                 wr_i,
  output tlb_res_e             res_o,
  output logic [PA_W-1:0]      pa_o,
  output logic                 wr_perm_o,
  output logic [N_ENTRIES-1:0] win_o
);
  // scan from the top so the lowest hitting index ends up winning
  always_comb begin
    res_o     = RES_NOMATCH;
    pa_o      = '0;
    wr_perm_o = 1'b0;
    win_o     = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        win_o     = '0;
        win_o[i]  = 1'b1;
        pa_o      = '0;
        wr_perm_o = 1'b0;
        if (!valid_i[i]) begin
          res_o = RES_INVALID;
        end else if (wr_i && !dirty_i[i]) begin
          res_o = RES_DIRTY;
        end else begin
          res_o     = RES_MATCH;
          pa_o      = pa_i[i];
          wr_perm_o = dirty_i[i];
        end
      end
    end
  end
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlb_lookup_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned VA_W      = 32,
  parameter int unsigned PA_W      = 32,
  parameter int unsigned ASID_W    = 8,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              wr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [VA_W-1:0]   wvpn_i,
  input  logic [VA_W-1:0]   wmask_i,
  input  logic [ASID_W-1:0] wasid_i,
  input  logic              wglobal_i,
  input  logic [PA_W-1:0]   wpfn0_i,
  input  logic [PA_W-1:0]   wpfn1_i,
  input  logic              wv0_i,
  input  logic              wv1_i,
  input  logic              wd0_i,
  input  logic              wd1_i,
  output logic [PA_W-1:0]   pa_o,
  output logic              wr_perm_o,
  output logic [2:0]        res_o,
  output logic              rsp_valid_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic              rsp_wr_perm_o,
  output logic [2:0]        rsp_res_o
);
  logic [VA_W-1:0]   vpn_q    [N_ENTRIES];
  logic [VA_W-1:0]   mask_q   [N_ENTRIES];
  logic [ASID_W-1:0] asid_q   [N_ENTRIES];
  logic              global_q [N_ENTRIES];
  logic [PA_W-1:0]   pfn0_q   [N_ENTRIES];
  logic [PA_W-1:0]   pfn1_q   [N_ENTRIES];
  logic              v0_q     [N_ENTRIES];
  logic              v1_q     [N_ENTRIES];
  logic              d0_q     [N_ENTRIES];
  logic              d1_q     [N_ENTRIES];

  logic [N_ENTRIES-1:0] hit_vec, valid_vec, dirty_vec, win_vec;
  logic [PA_W-1:0]      slice_pa [N_ENTRIES];
  tlb_res_e             res;

  tlb_entry_store #(
    .N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)
  ) store_i (
    .clk_i, .rst_ni, .we_i, .widx_i, .wvpn_i, .wmask_i, .wasid_i, .wglobal_i,
    .wpfn0_i, .wpfn1_i, .wv0_i, .wv1_i, .wd0_i, .wd1_i,
    .vpn_o(vpn_q), .mask_o(mask_q), .asid_o(asid_q), .global_o(global_q),
    .pfn0_o(pfn0_q), .pfn1_o(pfn1_q), .v0_o(v0_q), .v1_o(v1_q),
    .d0_o(d0_q), .d1_o(d1_q)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_slice
    tlb_match_slice #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W)) slice_i (
      .va_i, .asid_i,
      .vpn_i(vpn_q[g]), .mask_i(mask_q[g]), .easid_i(asid_q[g]),
      .global_i(global_q[g]), .pfn0_i(pfn0_q[g]), .pfn1_i(pfn1_q[g]),
      .v0_i(v0_q[g]), .v1_i(v1_q[g]), .d0_i(d0_q[g]), .d1_i(d1_q[g]),
      .hit_o(hit_vec[g]), .valid_o(valid_vec[g]), .dirty_o(dirty_vec[g]),
      .pa_o(slice_pa[g])
    );
  end

  tlb_priority_sel #(.N_ENTRIES(N_ENTRIES), .PA_W(PA_W)) sel_i (
    .hit_i(hit_vec), .valid_i(valid_vec), .dirty_i(dirty_vec), .pa_i(slice_pa),
    .wr_i, .res_o(res), .pa_o, .wr_perm_o, .win_o(win_vec)
  );

  assign res_o = res;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_pa_o      <= '0;
      rsp_wr_perm_o <= 1'b0;
      rsp_res_o     <= 3'b000;
    end else begin
      rsp_valid_o <= req_i;
      if (req_i) begin
        rsp_pa_o      <= pa_o;
        rsp_wr_perm_o <= wr_perm_o;
        rsp_res_o     <= res_o;
      end
    end
  end

  a_r7_single_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(win_vec) && ((win_vec & ~hit_vec) == '0));
  a_r6_perm_only_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_perm_o |-> (res_o == RES_MATCH));
  a_r5_dirty_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o == RES_DIRTY) |-> wr_i);
  a_r8_nomatch_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_o == RES_NOMATCH) |-> (hit_vec == '0));
  a_r9_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o && (rsp_res_o == $past(res_o)) && (rsp_pa_o == $past(pa_o)));
  a_r9_rsp_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o && $stable(rsp_pa_o) && $stable(rsp_res_o));
endmodule

// File: tb/tlb_lookup_unit_tb_top.sv
module tlb_lookup_unit_tb_top;
  localparam int unsigned N  = 4;
  localparam int unsigned VW = 32;
  localparam int unsigned PW = 32;
  localparam int unsigned AW = 8;

  localparam logic [2:0] C_MATCH   = 3'b000;
  localparam logic [2:0] C_NOMATCH = 3'b110;
  localparam logic [2:0] C_INVALID = 3'b101;
  localparam logic [2:0] C_DIRTY   = 3'b100;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [VW-1:0] va_i = '0;
  logic wr_i = 1'b0;
  logic [AW-1:0] asid_i = '0;
  logic we_i = 1'b0;
  logic [1:0] widx_i = '0;
  logic [VW-1:0] wvpn_i = '0, wmask_i = '0;
  logic [AW-1:0] wasid_i = '0;
  logic wglobal_i = 1'b0;
  logic [PW-1:0] wpfn0_i = '0, wpfn1_i = '0;
  logic wv0_i = 1'b0, wv1_i = 1'b0, wd0_i = 1'b0, wd1_i = 1'b0;
  logic [PW-1:0] pa_o, rsp_pa_o;
  logic wr_perm_o, rsp_valid_o, rsp_wr_perm_o;
  logic [2:0] res_o, rsp_res_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  tlb_lookup_unit #(.N_ENTRIES(N), .VA_W(VW), .PA_W(PW), .ASID_W(AW)) dut_i (
    .clk_i, .rst_ni, .req_i, .va_i, .wr_i, .asid_i, .we_i, .widx_i, .wvpn_i,
    .wmask_i, .wasid_i, .wglobal_i, .wpfn0_i, .wpfn1_i, .wv0_i, .wv1_i,
    .wd0_i, .wd1_i, .pa_o, .wr_perm_o, .res_o, .rsp_valid_o, .rsp_pa_o,
    .rsp_wr_perm_o, .rsp_res_o
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive entry fields at a falling edge; they land at the next rising edge
  task automatic put_entry(input logic [1:0] idx, input logic [VW-1:0] vpn,
                           input logic [VW-1:0] msk, input logic [AW-1:0] asid,
                           input logic g, input logic [PW-1:0] p0, input logic [PW-1:0] p1,
                           input logic v0, input logic v1, input logic d0, input logic d1);
    @(negedge clk_i);
    we_i = 1'b1; widx_i = idx; wvpn_i = vpn; wmask_i = msk; wasid_i = asid;
    wglobal_i = g; wpfn0_i = p0; wpfn1_i = p1;
    wv0_i = v0; wv1_i = v1; wd0_i = d0; wd1_i = d1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic look(input string tag, input logic [VW-1:0] va, input logic [AW-1:0] asid,
                      input logic wr, input logic [2:0] e_res, input logic [PW-1:0] e_pa,
                      input logic e_perm);
    @(negedge clk_i);
    va_i = va; asid_i = asid; wr_i = wr;
    #2;
    chk({tag, " res"}, 64'(res_o), 64'(e_res));
    chk({tag, " pa"}, 64'(pa_o), 64'(e_pa));
    chk({tag, " perm"}, 64'(wr_perm_o), 64'(e_perm));
  endtask

  task automatic t_reset();
    #2;
    chk("R1 rsp_valid", 64'(rsp_valid_o), 64'd0);
    chk("R1 rsp_pa", 64'(rsp_pa_o), 64'd0);
    chk("R1 rsp_res", 64'(rsp_res_o), 64'd0);
    chk("R1 rsp_perm", 64'(rsp_wr_perm_o), 64'd0);
    rst_ni = 1'b1;
    look("R1 empty lookup", 32'h0040_0123, 8'h11, 1'b0, C_NOMATCH, 32'h0, 1'b0);
  endtask

  task automatic t_basic();
    put_entry(2'd0, 32'h0040_0000, 32'h0, 8'h11, 1'b0, 32'h0010_0000, 32'h0020_0000,
              1'b1, 1'b1, 1'b1, 1'b0);
    look("R3 even read", 32'h0040_0123, 8'h11, 1'b0, C_MATCH, 32'h0010_0123, 1'b1);
    look("R3 odd read", 32'h0040_1456, 8'h11, 1'b0, C_MATCH, 32'h0020_0456, 1'b0);
    look("R5 odd write clean", 32'h0040_1456, 8'h11, 1'b1, C_DIRTY, 32'h0, 1'b0);
    look("R5 even write dirty", 32'h0040_0123, 8'h11, 1'b1, C_MATCH, 32'h0010_0123, 1'b1);
    look("R2 asid mismatch", 32'h0040_0123, 8'h12, 1'b0, C_NOMATCH, 32'h0, 1'b0);
  endtask

  task automatic t_mask();
    put_entry(2'd1, 32'h0080_0000, 32'h0000_6000, 8'h00, 1'b1, 32'h0300_0000, 32'h0400_0000,
              1'b0, 1'b1, 1'b0, 1'b1);
    look("R2 global wide odd", 32'h0080_5678, 8'h33, 1'b0, C_MATCH, 32'h0400_1678, 1'b1);
    look("R4 invalid even", 32'h0080_2345, 8'h33, 1'b0, C_INVALID, 32'h0, 1'b0);
    look("R8 tag above mask", 32'h0080_9000, 8'h33, 1'b0, C_NOMATCH, 32'h0, 1'b0);
  endtask

  task automatic t_priority();
    put_entry(2'd2, 32'h0040_0000, 32'h0, 8'h00, 1'b1, 32'h0A00_0000, 32'h0B00_0000,
              1'b1, 1'b1, 1'b1, 1'b1);
    look("R7 low index faults", 32'h0040_1456, 8'h11, 1'b1, C_DIRTY, 32'h0, 1'b0);
    look("R7 fall to next", 32'h0040_1456, 8'h55, 1'b1, C_MATCH, 32'h0B00_0456, 1'b1);
    put_entry(2'd3, 32'h00C0_0000, 32'h0, 8'h00, 1'b1, 32'h0C00_0000, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    look("R6 last entry clean", 32'h00C0_0010, 8'h01, 1'b0, C_MATCH, 32'h0C00_0010, 1'b0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk_i);
    va_i = 32'h00C0_0010; asid_i = 8'h01; wr_i = 1'b0;
    we_i = 1'b1; widx_i = 2'd3; wvpn_i = 32'h00C0_0000; wmask_i = '0; wasid_i = '0;
    wglobal_i = 1'b1; wpfn0_i = 32'h0D00_0000; wpfn1_i = '0;
    wv0_i = 1'b1; wv1_i = 1'b0; wd0_i = 1'b0; wd1_i = 1'b0;
    #2;
    chk("R10 old contents", 64'(pa_o), 64'h0C00_0010);
    @(negedge clk_i);
    we_i = 1'b0;
    #2;
    chk("R10 new contents", 64'(pa_o), 64'h0D00_0010);
  endtask

  task automatic t_rsp();
    @(negedge clk_i);
    va_i = 32'h0040_0123; asid_i = 8'h11; wr_i = 1'b0; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0; va_i = 32'h0080_2345; asid_i = 8'h33;
    chk("R9 rsp_valid high", 64'(rsp_valid_o), 64'd1);
    chk("R9 rsp_pa", 64'(rsp_pa_o), 64'h0010_0123);
    chk("R9 rsp_res", 64'(rsp_res_o), 64'(C_MATCH));
    chk("R9 rsp_perm", 64'(rsp_wr_perm_o), 64'd1);
    @(negedge clk_i);
    chk("R9 rsp_valid low", 64'(rsp_valid_o), 64'd0);
    chk("R9 rsp_pa held", 64'(rsp_pa_o), 64'h0010_0123);
    chk("R9 rsp_res held", 64'(rsp_res_o), 64'(C_MATCH));
  endtask

  initial begin
    t_reset();
    t_basic();
    t_mask();
    t_priority();
    t_same_cycle();
    t_rsp();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule